// File: doc/BRIEF.md
# Power-of-two-base logarithm unit

This block computes the integer logarithm of an unsigned operand to a base of the form 2^p, where p is a small exponent supplied with the operand. The answer equals the position of the operand's highest set bit divided by p, with the fraction dropped. The unit also reports the operand's leading-zero count.

The leading-zero count comes from two combinational steps. The first spreads the highest set bit into every lower position. The second counts the ones in that spread word with a staged SWAR adder tree. A synthesis option can replace both steps with a plain priority scan.

The division by p is done by a loop that removes p from a working value once per clock. A caller presents an operand and an exponent with a start strobe while ready is high. The caller then waits for the one-cycle done pulse and reads the result, the leading-zero count and the error flag. These outputs stay valid until the next operation is accepted.

Top module: `log2p_unit`

## Requirements
- R1: When done pulses without error, clz_o equals the number of zero bits above the highest set bit of the accepted operand, and equals DATA_W for a zero operand.
- R2: When done pulses without error, result_o equals floor(m / p), where m is the bit index of the highest set bit (LSB = index 0). For example, operand 64 gives 6, 3 and 2 for p = 1, 2 and 3, and operand 16 with p = 1 gives 4.
- R3: A zero operand with a nonzero exponent completes in the cycle after acceptance, with done high, err_o low, clz_o = DATA_W and result_o = 0.
- R4: An exponent of 0 completes in the cycle after acceptance, with done high, err_o high and result_o = 0, whatever the operand.
- R5: For a nonzero operand and nonzero exponent, done rises exactly result_o + 2 cycles after the cycle in which start was accepted. The leading-zero step takes one cycle, and each subtraction takes one more.
- R6: done_o is high for exactly one cycle per accepted operation.
- R7: result_o, clz_o and err_o change only in a cycle where done_o is high, and hold their values otherwise.
- R8: A start strobe while ready_o is low is ignored. The running operation finishes with its own result, and no further operation begins.
- R9: ready_o falls in the cycle after a start that enters the loop. It next rises only together with done_o.
- R10: Every exponent value from 1 to 2^EXP_W − 1 is handled. This includes the values 1 through 4 at minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when ready_o is high |
| operand_i | input | DATA_W | Unsigned operand |
| exp_i | input | EXP_W | Base exponent p (base is 2^p) |
| ready_o | output | 1 | Unit idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation had exponent 0 |
| result_o | output | $clog2(DATA_W)+1 | floor(log base 2^p) of the last operand |
| clz_o | output | $clog2(DATA_W)+1 | Leading-zero count of the last operand |

## Verification
The bench builds the unit with its defaults: a 64-bit operand, a 3-bit exponent and the SWAR leading-zero path. The 3-bit exponent brings p = 0 and p from 5 to 7 within reach, in addition to the required 1 through 4. This exercises both the rejection path and quotients where the highest-bit index is smaller than p. The full 64-bit width puts the spread-and-count path under stress at both extremes, from a lone bit 0 to an all-ones word. Latency is measured for every operation, so the one-subtraction-per-cycle timing is confirmed across quotients from 0 to 63.

// File: rtl/log2p_pkg.sv
package log2p_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_LOOP = 1'b1
   } log2p_state_e;

   localparam int CLZ_SWAR = 0;
   localparam int CLZ_SCAN = 1;

endpackage

// File: rtl/log2p_smear.sv
module log2p_smear #(
   parameter int W = 64
) (
   input  logic [W-1:0] in_i,
   output logic [W-1:0] out_o
);
   localparam int STAGES = $clog2(W);

   logic [W-1:0] st [0:STAGES];

   assign st[0] = in_i;

   // Each stage doubles the span of ones copied below the top set bit.
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      assign st[s+1] = st[s] | (st[s] >> (1 << s));
   end

   assign out_o = st[STAGES];
endmodule

// File: rtl/log2p_popcnt.sv
module log2p_popcnt #(
   parameter int W     = 64,
   parameter int OUT_W = 7
) (
   input  logic [W-1:0]     in_i,
   output logic [OUT_W-1:0] cnt_o
);
   localparam int STAGES = $clog2(W);

   if (W < 8 || W > 128 || (1 << STAGES) != W) begin : g_bad_w
      $error("log2p_popcnt: W must be a power of two from 8 to 128");
   end

   // Mask keeping the low half of every field of width 2^(s+1).
   function automatic logic [W-1:0] field_mask(int s);
      logic [W-1:0] m;
      m = '0;
      for (int i = 0; i < W; i++) begin
         if ((i % (2 << s)) < (1 << s)) m[i] = 1'b1;
      end
      return m;
   endfunction

   logic [W-1:0] st [0:STAGES];

   assign st[0] = in_i;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam logic [W-1:0] M = field_mask(s);
      if (s == 0) begin : g_pairs
         assign st[s+1] = st[s] - ((st[s] >> 1) & M);
      end else if (s == 1) begin : g_nibbles
         assign st[s+1] = ((st[s] >> 2) & M) + (st[s] & M);
      end else if (s == 2) begin : g_bytes
         assign st[s+1] = (st[s] + (st[s] >> 4)) & M;
      end else begin : g_accum
         // The low byte never exceeds W, so no carry leaks upward into it.
         assign st[s+1] = st[s] + (st[s] >> (1 << s));
      end
   end

   assign cnt_o = st[STAGES][OUT_W-1:0];
endmodule

// File: rtl/log2p_clz.sv
module log2p_clz #(
   parameter int W     = 64,
   parameter int OUT_W = 7,
   parameter int IMPL  = log2p_pkg::CLZ_SWAR
) (
   input  logic [W-1:0]     in_i,
   output logic [OUT_W-1:0] clz_o
);
   localparam logic [OUT_W-1:0] FULL = OUT_W'(W);

   if (IMPL == log2p_pkg::CLZ_SWAR) begin : g_swar
      logic [W-1:0]     smeared;
      logic [OUT_W-1:0] ones;

      log2p_smear #(.W(W)) u_smear (
         .in_i  (in_i),
         .out_o (smeared)
      );

      log2p_popcnt #(.W(W), .OUT_W(OUT_W)) u_pop (
         .in_i  (smeared),
         .cnt_o (ones)
      );

      assign clz_o = FULL - ones;
   end else begin : g_scan
      always_comb begin
         clz_o = FULL;
         for (int i = 0; i < W; i++) begin
            if (in_i[i]) clz_o = OUT_W'(W - 1 - i);
         end
      end
   end
endmodule

// File: rtl/log2p_step.sv
module log2p_step #(
   parameter int WORK_W = 8
) (
   input  logic [WORK_W-1:0] work_i,
   input  logic [WORK_W-1:0] sub_i,
   output logic [WORK_W-1:0] next_o,
   output logic              more_o
);
   assign next_o = work_i - sub_i;
   // Two's complement: the top bit marks a negative working value.
   assign more_o = !next_o[WORK_W-1] && (next_o != '0);
endmodule

// File: rtl/log2p_unit.sv
module log2p_unit #(
   parameter int DATA_W   = 64,
   parameter int EXP_W    = 3,
   parameter int CLZ_IMPL = log2p_pkg::CLZ_SWAR
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [DATA_W-1:0]           operand_i,
   input  logic [EXP_W-1:0]            exp_i,
   output logic                        ready_o,
   output logic                        done_o,
   output logic                        err_o,
   output logic [$clog2(DATA_W):0]     result_o,
   output logic [$clog2(DATA_W):0]     clz_o
);
   import log2p_pkg::*;

   localparam int RES_W  = $clog2(DATA_W) + 1;
   localparam int WORK_W = RES_W + 1;
   localparam logic [RES_W-1:0] FULL = RES_W'(DATA_W);

   if (EXP_W < 3 || EXP_W >= RES_W) begin : g_bad_exp
      $error("log2p_unit: EXP_W must reach p=4 and stay below RES_W");
   end
   if (CLZ_IMPL != CLZ_SWAR && CLZ_IMPL != CLZ_SCAN) begin : g_bad_impl
      $error("log2p_unit: unknown CLZ_IMPL");
   end

   log2p_state_e      state_q;
   logic [WORK_W-1:0] work_q;
   logic [WORK_W-1:0] sub_q;
   logic [RES_W-1:0]  cnt_q;
   logic [RES_W-1:0]  clz_hold_q;
   logic [RES_W-1:0]  clz_w;
   logic [WORK_W-1:0] next_w;
   logic              more_w;
   logic              accept;

   log2p_clz #(.W(DATA_W), .OUT_W(RES_W), .IMPL(CLZ_IMPL)) u_clz (
      .in_i  (operand_i),
      .clz_o (clz_w)
   );

   log2p_step #(.WORK_W(WORK_W)) u_step (
      .work_i (work_q),
      .sub_i  (sub_q),
      .next_o (next_w),
      .more_o (more_w)
   );

   assign ready_o = (state_q == ST_IDLE);
   assign accept  = start_i && ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         work_q     <= '0;
         sub_q      <= '0;
         cnt_q      <= '0;
         clz_hold_q <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         result_o   <= '0;
         clz_o      <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (exp_i == '0) begin
                     done_o   <= 1'b1;
                     err_o    <= 1'b1;
                     result_o <= '0;
                     clz_o    <= clz_w;
                  end else if (clz_w == FULL) begin
                     done_o   <= 1'b1;
                     err_o    <= 1'b0;
                     result_o <= '0;
                     clz_o    <= FULL;
                  end else begin
                     state_q    <= ST_LOOP;
                     work_q     <= {1'b0, FULL - clz_w};
                     sub_q      <= WORK_W'(exp_i);
                     cnt_q      <= '0;
                     clz_hold_q <= clz_w;
                  end
               end
            end
            ST_LOOP: begin
               if (more_w) begin
                  work_q <= next_w;
                  cnt_q  <= cnt_q + RES_W'(1);
               end else begin
                  state_q  <= ST_IDLE;
                  done_o   <= 1'b1;
                  err_o    <= 1'b0;
                  result_o <= cnt_q;
                  clz_o    <= clz_hold_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/log2p_unit_chk.sv
module log2p_unit_chk #(
   parameter int DATA_W = 64,
   parameter int EXP_W  = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [DATA_W-1:0]       operand_i,
   input logic [EXP_W-1:0]        exp_i,
   input logic                    ready_o,
   input logic                    done_o,
   input logic                    err_o,
   input logic [$clog2(DATA_W):0] result_o,
   input logic [$clog2(DATA_W):0] clz_o
);
   localparam int RES_W = $clog2(DATA_W) + 1;
   localparam logic [RES_W-1:0] FULL = RES_W'(DATA_W);
   localparam logic [RES_W-1:0] TOP  = RES_W'(DATA_W - 1);

   p_clz_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> clz_o <= FULL);

   p_res_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && clz_o < FULL) |-> result_o <= TOP - clz_o);

   p_zero_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ready_o && exp_i != '0 && operand_i == '0)
      |=> (done_o && !err_o && clz_o == FULL && result_o == '0));

   p_bad_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ready_o && exp_i == '0) |=> (done_o && err_o && result_o == '0));

   p_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(clz_o) && $stable(err_o)));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ready_o && exp_i != '0 && operand_i != '0) |=> !ready_o);

   p_ready_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> done_o);
endmodule

bind log2p_unit log2p_unit_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .operand_i (operand_i),
   .exp_i     (exp_i),
   .ready_o   (ready_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .result_o  (result_o),
   .clz_o     (clz_o)
);

// File: tb/log2p_unit_bench.sv
module log2p_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int EW = 3;
   localparam int RW = $clog2(DW) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [DW-1:0] operand_i = '0;
   logic [EW-1:0] exp_i = '0;
   logic          ready_o, done_o, err_o;
   logic [RW-1:0] result_o, clz_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   log2p_unit #(.DATA_W(DW), .EXP_W(EW)) u_log2p_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
      .exp_i(exp_i), .ready_o(ready_o), .done_o(done_o), .err_o(err_o),
      .result_o(result_o), .clz_o(clz_o)
   );

   function automatic int ref_clz(logic [DW-1:0] x);
      for (int i = DW - 1; i >= 0; i--) if (x[i]) return DW - 1 - i;
      return DW;
   endfunction

   function automatic int ref_log(logic [DW-1:0] x, int p);
      if (p == 0 || x == '0) return 0;
      return (DW - 1 - ref_clz(x)) / p;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // Runs one operation and checks R1..R7 and R10 on it.
   task automatic run_op(logic [DW-1:0] x, int p, bit busy_poke);
      int lat;
      int e_clz, e_res, e_lat;
      bit e_err;
      e_err = (p == 0);
      e_clz = ref_clz(x);
      e_res = ref_log(x, p);
      e_lat = (e_err || x == '0) ? 1 : e_res + 2;
      @(negedge clk);
      chk(ready_o == 1'b1, "R9 ready before start", ready_o, 1);
      operand_i = x;
      exp_i     = EW'(p);
      start_i   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      if (busy_poke && !done_o) begin
         // R8: a strobe with other data while busy must be ignored.
         operand_i = ~x;
         exp_i     = EW'(1);
         start_i   = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         lat++;
      end
      while (!done_o && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == e_lat, "R5 latency", lat, e_lat);
      chk(err_o == e_err, "R4 err flag", err_o, e_err);
      chk(clz_o == RW'(e_clz), "R1 clz", clz_o, e_clz);
      chk(result_o == RW'(e_res), "R2 R10 result", result_o, e_res);
      chk(ready_o == 1'b1, "R9 ready with done", ready_o, 1);
      @(negedge clk);
      chk(done_o == 1'b0, "R6 single pulse", done_o, 0);
      if (busy_poke) begin
         chk(ready_o == 1'b1, "R8 no extra operation", ready_o, 1);
         chk(result_o == RW'(e_res), "R8 result kept", result_o, e_res);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      logic [DW-1:0] rx;
      int rp;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(ready_o == 1'b1 && done_o == 1'b0, "R9 reset state", {ready_o, done_o}, 2);
      chk(result_o == '0 && clz_o == '0 && err_o == 1'b0, "R7 reset outputs",
          result_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(64'd64, 1, 0);          // R2: 6
      run_op(64'd64, 2, 0);          // R2: 3
      run_op(64'd64, 3, 0);          // R2: 2
      run_op(64'd16, 1, 0);          // R2: 4
      run_op(64'd1, 1, 0);           // lowest bit only
      run_op('1, 4, 0);              // R10: all ones, p=4
      run_op(64'd0, 2, 0);           // R3 zero operand
      run_op(64'd64, 0, 0);          // R4 bad exponent
      run_op(64'd0, 0, 0);           // R4 wins over zero
      run_op(64'h8000_0000_0000_0000, 7, 0);
      run_op(64'd64, 1, 1);          // R8 busy strobe

      // R7: outputs hold across idle cycles.
      repeat (5) @(negedge clk);
      chk(result_o == 7'd6 && clz_o == 7'd57, "R7 hold while idle", result_o, 6);

      for (int k = 0; k < 300; k++) begin
         rx = {$urandom, $urandom};
         rx = rx >> ($urandom % DW);
         if ($urandom % 16 == 0) rx = '0;
         rp = $urandom % (1 << EW);
         run_op(rx, rp, ($urandom % 8) == 0);
      end
      summary();
   end
endmodule